// File: doc/BRIEF.md
# Two-Way Indexed Microsequencer

This block generates the next control-store address for a microcoded controller. Every microinstruction carries a condition selector, two complete target addresses, and a dispatch-enable bit. The selector picks one status line, or a constant. A true line takes the first target and a false line takes the second. When dispatch is enabled, the zero-extended instruction opcode is added to the chosen target. This lets one microinstruction branch into a table of per-opcode entry points.

There is no incrementing microprogram counter, so sequential flow is written as a jump in which both targets are equal. Busy-wait loops on the memory handshake are written as a microinstruction whose true target is its own address. The address register holds the current microprogram address and drives the control-store index directly. A synchronous reset returns it to address 0, where instruction fetch begins.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `upc` becomes 0 after that edge, and it stays 0 for as long as `rst` stays high.
- R2: Condition code 0 (`cond_sel` = 3'd0) is a constant 1, so the next address is based on `tgt_true` whatever the four status inputs are.
- R3: Condition codes 1, 2, 3 and 4 select `st_carry`, `st_sign`, `st_ovf` and `st_busy` in that order. A selected value of 1 bases the next address on `tgt_true`, and a value of 0 bases it on `tgt_false`.
- R4: Condition codes 5, 6 and 7 are reserved and act as a constant 0, so the next address is based on `tgt_false`.
- R5: When `disp_en` is 1, the 6-bit `opcode` is zero-extended to 8 bits and added to the chosen base address to form the next address.
- R6: The dispatch sum wraps modulo 256. For example, base 8'hFA plus opcode 6'h3F gives 8'h39.
- R7: When `disp_en` is 0, `opcode` has no effect and the next address equals the chosen base.
- R8: When `tgt_true` equals `tgt_false` and `disp_en` is 0, the next address is that target for every condition code and every status value.
- R9: A microinstruction with condition code 4 whose true target is the current `upc` holds `upc` unchanged while `st_busy` is 1. It moves to `tgt_false` on the first edge at which `st_busy` is 0.
- R10: `upc` is registered. It changes only at a rising clock edge, and the value it takes there is computed from the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to address 0 |
| cond_sel | input | 3 | Condition selector field of the current microinstruction |
| tgt_true | input | 8 | Target used when the selected condition is 1 |
| tgt_false | input | 8 | Target used when the selected condition is 0 |
| disp_en | input | 1 | Adds the opcode to the chosen target when 1 |
| opcode | input | 6 | Opcode field of the instruction register |
| st_carry | input | 1 | Carry-out status from the ALU |
| st_sign | input | 1 | Sign of the ALU result |
| st_ovf | input | 1 | Overflow status from the ALU |
| st_busy | input | 1 | Memory still busy with a read or write |
| upc | output | 8 | Registered microprogram address (control-store index) |

## Verification
The in-RTL properties check on every cycle the relation between one cycle's fields and the next address in several cases:
- the reset value;
- the constant-true code;
- the reserved codes;
- equal-target jumps;
- the busy self-loop.

Only the bench scenarios show the following:
- the exact sum for dispatch, including the wrap past 255;
- that each of the four status lines is routed to its own code;
- that a changed opcode is ignored when dispatch is off;
- that `upc` stays steady between edges.

// File: rtl/useq_pkg.sv
package useq_pkg;

  parameter int unsigned USEQ_ADDR_W = 8;
  parameter int unsigned USEQ_OP_W   = 6;
  parameter int unsigned USEQ_SEL_W  = 3;
  parameter int unsigned USEQ_NSTAT  = 4;

  // Condition selector codes; order of status lines is fixed by decoding
  typedef enum logic [USEQ_SEL_W-1:0] {
    COND_ALWAYS = 3'd0,
    COND_CARRY  = 3'd1,
    COND_SIGN   = 3'd2,
    COND_OVF    = 3'd3,
    COND_BUSY   = 3'd4
  } cond_code_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned NSTAT = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSTAT-1:0] status,
  output logic             taken
);

  // Code 0 is constant true, codes 1..NSTAT pick status[code-1],
  // every remaining code reads as constant false.
  always_comb begin
    taken = 1'b0;
    if (sel == '0) begin
      taken = 1'b1;
    end else begin
      for (int i = 0; i < int'(NSTAT); i++) begin
        if (sel == SEL_W'(i + 1)) taken = status[i];
      end
    end
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OP_W   = 6
) (
  input  logic              taken,
  input  logic [ADDR_W-1:0] tgt_true,
  input  logic [ADDR_W-1:0] tgt_false,
  input  logic              disp_en,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] op_ext;

  // Zero-extend or truncate the opcode to the address width
  generate
    if (OP_W < ADDR_W) begin : g_pad
      assign op_ext = {{(ADDR_W-OP_W){1'b0}}, opcode};
    end else begin : g_trunc
      assign op_ext = opcode[ADDR_W-1:0];
    end
  endgenerate

  assign base      = taken ? tgt_true : tgt_false;
  assign next_addr = base + (disp_en ? op_ext : '0);  // wraps mod 2**ADDR_W

endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (q == '0)); // R1

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = USEQ_ADDR_W,
  parameter int unsigned OP_W   = USEQ_OP_W,
  parameter int unsigned SEL_W  = USEQ_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [ADDR_W-1:0] tgt_true,
  input  logic [ADDR_W-1:0] tgt_false,
  input  logic              disp_en,
  input  logic [OP_W-1:0]   opcode,
  input  logic              st_carry,
  input  logic              st_sign,
  input  logic              st_ovf,
  input  logic              st_busy,
  output logic [ADDR_W-1:0] upc
);

  localparam int unsigned NSTAT = USEQ_NSTAT;

  logic [NSTAT-1:0]  status_vec;
  logic              taken;
  logic [ADDR_W-1:0] next_addr;

  // Bit i is selected by code i+1
  assign status_vec = {st_busy, st_ovf, st_sign, st_carry};

  useq_cond_mux #(.SEL_W(SEL_W), .NSTAT(NSTAT)) u_cond (
    .sel    (cond_sel),
    .status (status_vec),
    .taken  (taken)
  );

  useq_dispatch #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_disp (
    .taken     (taken),
    .tgt_true  (tgt_true),
    .tgt_false (tgt_false),
    .disp_en   (disp_en),
    .opcode    (opcode),
    .next_addr (next_addr)
  );

  useq_upc_reg #(.ADDR_W(ADDR_W)) u_upc (
    .clk (clk),
    .rst (rst),
    .d   (next_addr),
    .q   (upc)
  );

  AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_ALWAYS) && !disp_en) |=> (upc == $past(tgt_true))); // R2

  AST_RESERVED_FALSE: assert property (@(posedge clk) disable iff (rst)
    (cond_sel > SEL_W'(NSTAT) && !disp_en) |=> (upc == $past(tgt_false))); // R4

  AST_EQUAL_TARGETS: assert property (@(posedge clk) disable iff (rst)
    (tgt_true == tgt_false && !disp_en) |=> (upc == $past(tgt_true))); // R8

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_BUSY) && st_busy && !disp_en && tgt_true == upc)
    |=> $stable(upc)); // R9

endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cond_sel = '0;
  logic [7:0] tgt_true = '0, tgt_false = '0;
  logic       disp_en = 1'b0;
  logic [5:0] opcode = '0;
  logic       st_carry = 1'b0, st_sign = 1'b0, st_ovf = 1'b0, st_busy = 1'b0;
  logic [7:0] upc;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic [7:0] last_exp = '0;

  always #2 clk = ~clk;  // 250 MHz

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .tgt_true(tgt_true),
    .tgt_false(tgt_false), .disp_en(disp_en), .opcode(opcode),
    .st_carry(st_carry), .st_sign(st_sign), .st_ovf(st_ovf),
    .st_busy(st_busy), .upc(upc)
  );

  // Reference next address, written from the requirements
  function automatic logic [7:0] ref_next(input logic r, input logic [2:0] s,
      input logic [7:0] t, input logic [7:0] f, input logic d, input logic [5:0] o,
      input logic [3:0] st);  // st = {busy, ovf, sign, carry}
    logic c;
    logic [7:0] b;
    if (r) return 8'h00;
    case (s)
      3'd0: c = 1'b1;
      3'd1: c = st[0];
      3'd2: c = st[1];
      3'd3: c = st[2];
      3'd4: c = st[3];
      default: c = 1'b0;
    endcase
    b = c ? t : f;
    return d ? 8'(b + {2'b00, o}) : b;
  endfunction

  // Driver: applies one microinstruction at the falling edge and queues the expected address
  task automatic step(input logic r, input logic [2:0] s, input logic [7:0] t,
      input logic [7:0] f, input logic d, input logic [5:0] o,
      input logic [3:0] st, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; cond_sel = s; tgt_true = t; tgt_false = f; disp_en = d; opcode = o;
    {st_busy, st_ovf, st_sign, st_carry} = st;
    it.exp = ref_next(r, s, t, f, d, o, st);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        last_exp = it.exp;
        if (upc !== it.exp) begin
          n_fail++;
          $display("FAIL %s: upc=%h expected=%h", it.tag, upc, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1 reset state, held over two edges
    step(1, 3'd0, 8'h55, 8'h66, 0, 6'h0, 4'hF, "R1 reset");
    step(1, 3'd0, 8'h55, 8'h66, 1, 6'h3, 4'hF, "R1 reset held");
    // R2 constant true, status all zero then all one
    step(0, 3'd0, 8'h12, 8'h34, 0, 6'h0, 4'h0, "R2 code0 status0");
    step(0, 3'd0, 8'h22, 8'h34, 0, 6'h0, 4'hF, "R2 code0 status1");
    // R3 each status line alone, both polarities
    for (int i = 0; i < 4; i++) begin
      step(0, 3'(i + 1), 8'hA0, 8'h50, 0, 6'h0, 4'(1 << i), "R3 line high");
      step(0, 3'(i + 1), 8'hA1, 8'h51, 0, 6'h0, 4'(~(1 << i)), "R3 line low");
    end
    // R4 reserved codes with all status high
    step(0, 3'd5, 8'hC0, 8'h0D, 0, 6'h0, 4'hF, "R4 code5");
    step(0, 3'd6, 8'hC1, 8'h0E, 0, 6'h0, 4'hF, "R4 code6");
    step(0, 3'd7, 8'hC2, 8'h0F, 0, 6'h0, 4'hF, "R4 code7");
    // R5 dispatch on both branches
    step(0, 3'd0, 8'h05, 8'h99, 1, 6'h07, 4'h0, "R5 dispatch true base");
    step(0, 3'd1, 8'h10, 8'h05, 1, 6'h07, 4'h0, "R5 dispatch false base");
    // R6 wrap
    step(0, 3'd0, 8'hFA, 8'h00, 1, 6'h3F, 4'h0, "R6 wrap");
    // R7 opcode ignored without dispatch
    step(0, 3'd0, 8'h20, 8'h30, 0, 6'h2A, 4'h0, "R7 opcode ignored");
    step(0, 3'd0, 8'h20, 8'h30, 0, 6'h15, 4'h0, "R7 opcode ignored again");
    // R8 equal targets with varied conditions
    step(0, 3'd2, 8'h77, 8'h77, 0, 6'h0, 4'h2, "R8 equal sign1");
    step(0, 3'd3, 8'h78, 8'h78, 0, 6'h0, 4'h0, "R8 equal ovf0");
    // R9 busy self-loop
    step(0, 3'd0, 8'h40, 8'h40, 0, 6'h0, 4'h0, "R9 enter loop");
    for (int k = 0; k < 3; k++) step(0, 3'd4, 8'h40, 8'h41, 0, 6'h0, 4'h8, "R9 hold busy");
    step(0, 3'd4, 8'h40, 8'h41, 0, 6'h0, 4'h0, "R9 exit");
    // R10 output steady between edges after inputs change
    @(negedge clk);
    cond_sel = 3'd0; tgt_true = 8'hEE; tgt_false = 8'hEE; disp_en = 1'b1; opcode = 6'h11;
    #1;
    n_checks++;
    if (upc !== last_exp) begin
      n_fail++;
      $display("FAIL R10 mid-cycle: upc=%h expected=%h", upc, last_exp);
    end
    // R1 reset mid-run
    step(1, 3'd0, 8'h90, 8'h90, 0, 6'h0, 4'h0, "R1 mid-run reset");
    step(0, 3'd0, 8'h03, 8'h03, 0, 6'h0, 4'h0, "R1 after reset");
    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule